// File: doc/BRIEF.md
# Snooping Cache Controller with Idle Refill

This block controls the tag side of a small private cache that sits beside one processor on a bus shared by several masters. The processor sends lookup requests over a valid/ready port and receives one hit/miss response per accepted request. On a miss, the block becomes the bus master and fetches the line from memory through a request/grant/data-valid handshake. The data array itself lives outside this block. Only tags, valid bits and stale bits are kept here.

A second input carries every transaction seen on the shared bus. A write from any other master whose address is present in the cache does not overwrite the line: the line is flagged stale. A later processor access to a stale line counts as a miss and fetches the line again. When the idle-refill enable is set, a background engine refetches stale lines on its own in bus cycles that nobody else is using. Later accesses to those lines then hit without waiting.

The cache is direct-mapped. The low `IDX_W` address bits select a line, and the remaining upper bits form the tag. Back-pressure applies only on the request side. `cpu_req_ready` falls in the cycle after a miss is accepted and rises again once that miss's refill has delivered its data. The response has no ready, so the processor must always take it.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: A synchronous reset clears every valid and stale bit. After reset `cpu_req_ready` is 1, and `bus_req` and `cpu_rsp_valid` are 0, so the first access to any address misses.
- R2: A request is accepted in a cycle with `cpu_req_valid` and `cpu_req_ready` both 1. Exactly one cycle later `cpu_rsp_valid` is 1, and it is 0 in every cycle that does not follow an acceptance. `cpu_rsp_hit` is 1 exactly when, in the acceptance cycle, the indexed line is valid, not stale and holds the request's tag.
- R3: After a miss, `cpu_req_ready` is 0 and `bus_req` is raised with `bus_addr` equal to the missing address. The first `bus_dvalid` after the grant installs the line as valid and not stale and raises `cpu_req_ready` again, so a repeat access hits.
- R4: A bus-monitor write (`mon_valid`=1, `mon_write`=1) from another master whose address matches a valid line marks that line stale, and the next access to it misses and refetches it. Monitor reads, and writes whose tag differs from the stored one, leave the line's hit status unchanged.
- R5: Monitor transactions whose `mon_id` equals the block's own `SELF_ID` never change any line.
- R6: With `bg_en`=1, no pending miss, at least one stale line, and `bus_busy` low in the current cycle and the previous one, the block requests the bus with the full address of a stale line. After its data strobe, that line hits again. With `bg_en`=0 no background request is made.
- R7: Background refills pick stale lines in circular index order. The search starts one index past the line refilled last (index 0 after reset).
- R8: A processor miss overrides a background request that has not yet been granted: `bus_addr` switches to the miss address. A background refill that has already been granted finishes first, and the miss is requested after it.
- R9: If a foreign write to the exact refill address is seen in the cycle of that refill's data strobe, the line is installed stale, and the next access misses.
- R10: `bus_req` stays high until `bus_gnt` is seen, drops in the cycle after the grant, and stays low until the data strobe, so at most one refill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bg_en | input | 1 | Enables background refill of stale lines |
| cpu_req_valid | input | 1 | Processor lookup request valid |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_addr | input | ADDR_W | Processor word address |
| cpu_rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| cpu_rsp_hit | output | 1 | 1 = hit, 0 = miss |
| bus_req | output | 1 | Bus request for a refill |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | ADDR_W | Refill address |
| bus_dvalid | input | 1 | One-cycle refill data strobe |
| bus_busy | input | 1 | Shared bus in use by another master |
| mon_valid | input | 1 | Monitored bus transaction present |
| mon_write | input | 1 | Monitored transaction is a write |
| mon_id | input | ID_W | Master identifier of monitored transaction |
| mon_addr | input | ADDR_W | Address of monitored transaction |

## Verification
The response to an accepted request is due one clock edge after acceptance. The bench computes the expected hit from its own tag model as it stands before that edge, then samples on the following falling edge. A miss raises `bus_req` two edges after acceptance: one edge to latch the pending miss and one for the refill engine to enter its request state. The bench waits for the request rather than counting, then checks the address as soon as the request is seen. Tag and stale updates from a data strobe or a snoop take effect at the edge where they are sampled. The model applies them in the same step, so the next lookup sees them. Grants and strobes are driven one per step, and the cycle after a grant is checked for a dropped `bus_req`.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_XFER = 2'd2
  } rf_state_e;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_BG  = 1'b1
  } rf_src_e;
endpackage

// File: rtl/cc_tagstore.sv
module cc_tagstore #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         lk_addr,
  output logic                      lk_hit,
  input  logic                      snp_en,
  input  logic [ADDR_W-1:0]         snp_addr,
  input  logic                      fill_en,
  input  logic [ADDR_W-1:0]         fill_addr,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [ADDR_W-IDX_W-1:0]   rd_tag,
  output logic [(1<<IDX_W)-1:0]     stale_vec
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tag_w [LINES];
  logic [LINES-1:0] valid_w;
  logic [LINES-1:0] stale_w;

  logic [IDX_W-1:0] lk_idx, snp_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, snp_tag, fill_tag;
  logic             snp_on_fill;

  assign lk_idx   = lk_addr[IDX_W-1:0];
  assign lk_tag   = lk_addr[ADDR_W-1:IDX_W];
  assign snp_idx  = snp_addr[IDX_W-1:0];
  assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr[IDX_W-1:0];
  assign fill_tag = fill_addr[ADDR_W-1:IDX_W];
  // a foreign write to the very line being installed keeps it stale
  assign snp_on_fill = snp_en && (snp_addr == fill_addr);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TAG_W-1:0] t_q;
    logic             v_q;
    logic             s_q;
    logic             hit_snp;
    logic             hit_fill;

    assign hit_snp  = snp_en && v_q && (snp_idx == IDX_W'(i)) && (t_q == snp_tag);
    assign hit_fill = fill_en && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        t_q <= '0;
        v_q <= 1'b0;
        s_q <= 1'b0;
      end else if (hit_fill) begin
        t_q <= fill_tag;
        v_q <= 1'b1;
        s_q <= snp_on_fill;
      end else if (hit_snp) begin
        s_q <= 1'b1;
      end
    end

    assign tag_w[i]   = t_q;
    assign valid_w[i] = v_q;
    assign stale_w[i] = s_q;
  end

  assign lk_hit    = valid_w[lk_idx] && !stale_w[lk_idx] && (tag_w[lk_idx] == lk_tag);
  assign rd_tag    = tag_w[rd_idx];
  assign stale_vec = stale_w & valid_w;
endmodule

// File: rtl/cc_stale_pick.sv
module cc_stale_pick #(
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<IDX_W)-1:0] stale_vec,
  input  logic                  advance,
  output logic [IDX_W-1:0]      pick_idx,
  output logic                  any_stale
);
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] rr_q;

  always_comb begin
    logic [IDX_W-1:0] cand;
    pick_idx  = rr_q;
    any_stale = 1'b0;
    for (int k = 0; k < LINES; k++) begin
      cand = rr_q + IDX_W'(k);
      if (!any_stale && stale_vec[cand]) begin
        pick_idx  = cand;
        any_stale = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rr_q <= '0;
    else if (advance) rr_q <= pick_idx + IDX_W'(1);
  end
endmodule

// File: rtl/cc_refill_fsm.sv
module cc_refill_fsm
  import cc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_pend,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              bg_ok,
  input  logic [ADDR_W-1:0] bg_addr,
  input  logic              bus_gnt,
  input  logic              bus_dvalid,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bg_take,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              miss_done
);
  rf_state_e         st_q;
  rf_src_e           src_q;
  logic [ADDR_W-1:0] addr_q;

  assign bg_take   = (st_q == RF_IDLE) && !miss_pend && bg_ok;
  assign bus_req   = (st_q == RF_REQ);
  assign bus_addr  = addr_q;
  assign fill_en   = (st_q == RF_XFER) && bus_dvalid;
  assign fill_addr = addr_q;
  assign miss_done = fill_en && (src_q == SRC_CPU);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RF_IDLE;
      src_q  <= SRC_CPU;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        RF_IDLE: begin
          if (miss_pend) begin
            st_q   <= RF_REQ;
            src_q  <= SRC_CPU;
            addr_q <= miss_addr;
          end else if (bg_ok) begin
            st_q   <= RF_REQ;
            src_q  <= SRC_BG;
            addr_q <= bg_addr;
          end
        end
        RF_REQ: begin
          if (bus_gnt) begin
            st_q <= RF_XFER;
          end else if (src_q == SRC_BG && miss_pend) begin
            src_q  <= SRC_CPU;
            addr_q <= miss_addr;
          end
        end
        RF_XFER: begin
          if (bus_dvalid) st_q <= RF_IDLE;
        end
        default: st_q <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 4,
  parameter int ID_W    = 2,
  parameter int SELF_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bg_en,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dvalid,
  input  logic              bus_busy,
  input  logic              mon_valid,
  input  logic              mon_write,
  input  logic [ID_W-1:0]   mon_id,
  input  logic [ADDR_W-1:0] mon_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              pend_miss_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              rsp_v_q, rsp_h_q;
  logic              idle_q;

  logic              accept, lk_hit, snp_en, bg_ok, bg_take;
  logic              fill_en, miss_done, any_stale;
  logic [ADDR_W-1:0] fill_addr, bg_addr;
  logic [IDX_W-1:0]  pick_idx;
  logic [TAG_W-1:0]  pick_tag;
  logic [LINES-1:0]  stale_vec;

  assign cpu_req_ready = !pend_miss_q;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign snp_en        = mon_valid && mon_write && (mon_id != ID_W'(SELF_ID));
  assign bg_ok         = bg_en && any_stale && !pend_miss_q && idle_q && !bus_busy;
  assign bg_addr       = {pick_tag, pick_idx};
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_hit   = rsp_h_q;

  cc_tagstore #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .lk_addr   (cpu_req_addr),
    .lk_hit    (lk_hit),
    .snp_en    (snp_en),
    .snp_addr  (mon_addr),
    .fill_en   (fill_en),
    .fill_addr (fill_addr),
    .rd_idx    (pick_idx),
    .rd_tag    (pick_tag),
    .stale_vec (stale_vec)
  );

  cc_stale_pick #(.IDX_W(IDX_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .stale_vec (stale_vec),
    .advance   (bg_take),
    .pick_idx  (pick_idx),
    .any_stale (any_stale)
  );

  cc_refill_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .miss_pend  (pend_miss_q),
    .miss_addr  (miss_addr_q),
    .bg_ok      (bg_ok),
    .bg_addr    (bg_addr),
    .bus_gnt    (bus_gnt),
    .bus_dvalid (bus_dvalid),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bg_take    (bg_take),
    .fill_en    (fill_en),
    .fill_addr  (fill_addr),
    .miss_done  (miss_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_miss_q <= 1'b0;
      miss_addr_q <= '0;
      rsp_v_q     <= 1'b0;
      rsp_h_q     <= 1'b0;
      idle_q      <= 1'b0;
    end else begin
      rsp_v_q <= accept;
      rsp_h_q <= accept && lk_hit;
      idle_q  <= !bus_busy;
      if (accept && !lk_hit) begin
        pend_miss_q <= 1'b1;
        miss_addr_q <= cpu_req_addr;
      end else if (miss_done) begin
        pend_miss_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl_chk.sv
module snoop_cache_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bg_en,
  input logic cpu_req_valid,
  input logic cpu_req_ready,
  input logic cpu_rsp_valid,
  input logic cpu_rsp_hit,
  input logic bus_req,
  input logic bus_gnt,
  input logic bus_busy,
  input logic pend_miss
);
  // R1: outputs idle right after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!bus_req && !cpu_rsp_valid && cpu_req_ready));

  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> cpu_rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !(cpu_req_valid && cpu_req_ready) |=> !cpu_rsp_valid);

  p_miss_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && !cpu_rsp_hit) |-> !cpu_req_ready);

  p_bg_needs_enable_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(pend_miss) || $past(bg_en)));

  p_bg_needs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_req) && !$past(pend_miss)) |-> !$past(bus_busy));

  p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);

  p_req_drops_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> !bus_req);
endmodule

bind snoop_cache_ctrl snoop_cache_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .bg_en         (bg_en),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_hit   (cpu_rsp_hit),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_busy      (bus_busy),
  .pend_miss     (pend_miss_q)
);

// File: tb/snoop_cache_ctrl_test.sv
module snoop_cache_ctrl_test;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int NL = 1 << IW;
  localparam int TW = AW - IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bg_en = 1'b0;
  logic cpu_req_valid = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic bus_gnt = 1'b0, bus_dvalid = 1'b0, bus_busy = 1'b0;
  logic mon_valid = 1'b0, mon_write = 1'b0;
  logic [1:0] mon_id = '0;
  logic [AW-1:0] mon_addr = '0;
  logic cpu_req_ready, cpu_rsp_valid, cpu_rsp_hit, bus_req;
  logic [AW-1:0] bus_addr;

  always #2 clk = ~clk;

  snoop_cache_ctrl #(.ADDR_W(AW), .IDX_W(IW), .ID_W(2), .SELF_ID(0)) uut (
    .clk(clk), .rst(rst), .bg_en(bg_en),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_hit(cpu_rsp_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_dvalid(bus_dvalid), .bus_busy(bus_busy),
    .mon_valid(mon_valid), .mon_write(mon_write), .mon_id(mon_id),
    .mon_addr(mon_addr)
  );

  int checks = 0, errors = 0;
  bit m_v [NL];
  bit m_s [NL];
  logic [TW-1:0] m_t [NL];
  bit xfer = 0;
  logic [AW-1:0] xaddr = '0;
  logic [AW-1:0] pend_addr = '0;
  bit last_acc = 0, last_hit = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [AW-1:0] a);
    int i = int'(a[IW-1:0]);
    return m_v[i] && !m_s[i] && (m_t[i] == a[AW-1:IW]);
  endfunction

  function automatic bit m_stale_addr(input logic [AW-1:0] a);
    int i = int'(a[IW-1:0]);
    return m_v[i] && m_s[i] && (m_t[i] == a[AW-1:IW]);
  endfunction

  // one clock: model the edge from driven inputs, then check the response
  task automatic step();
    bit acc, eh, snp, fil;
    int fi, si;
    acc = cpu_req_valid && cpu_req_ready;
    eh  = m_hit(cpu_req_addr);
    if (acc && !eh) pend_addr = cpu_req_addr;
    fil = xfer && bus_dvalid;
    if (bus_req && bus_gnt && !xfer) begin
      // R6 R8: granted refill targets the pending miss or a stale line
      chk((!cpu_req_ready && bus_addr == pend_addr) || m_stale_addr(bus_addr),
          "R8 granted address legal", int'(bus_addr), int'(pend_addr));
      xfer = 1; xaddr = bus_addr;
    end
    snp = mon_valid && mon_write && (mon_id != 2'd0);
    fi  = int'(xaddr[IW-1:0]);
    si  = int'(mon_addr[IW-1:0]);
    if (snp && !(fil && si == fi) && m_v[si] && m_t[si] == mon_addr[AW-1:IW])
      m_s[si] = 1;
    if (fil) begin
      m_v[fi] = 1; m_t[fi] = xaddr[AW-1:IW];
      m_s[fi] = snp && (mon_addr == xaddr);
      xfer = 0;
    end
    @(posedge clk);
    @(negedge clk);
    last_acc = acc;
    if (acc) begin
      chk(cpu_rsp_valid == 1'b1, "R2 response due", int'(cpu_rsp_valid), 1);
      chk(cpu_rsp_hit == eh, "R2 hit value", int'(cpu_rsp_hit), int'(eh));
      last_hit = cpu_rsp_hit;
    end else begin
      chk(cpu_rsp_valid == 1'b0, "R2 no spurious response", int'(cpu_rsp_valid), 0);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input bit exp, input string what);
    cpu_req_valid = 1; cpu_req_addr = a;
    while (!cpu_req_ready) step();
    step();
    cpu_req_valid = 0;
    chk(last_hit == exp, what, int'(last_hit), int'(exp));
  endtask

  task automatic serve(input logic [AW-1:0] a, input string what, input bit snoop);
    int n = 0;
    while (!bus_req && n < 60) begin step(); n++; end
    chk(bus_req && bus_addr == a, what, int'(bus_addr), int'(a));
    bus_gnt = 1; step(); bus_gnt = 0;
    chk(!bus_req, "R10 request drops after grant", int'(bus_req), 0);
    bus_dvalid = 1;
    if (snoop) begin mon_valid = 1; mon_write = 1; mon_id = 2'd1; mon_addr = a; end
    step();
    bus_dvalid = 0; mon_valid = 0;
  endtask

  task automatic fwrite(input logic [AW-1:0] a, input logic [1:0] id, input bit wr);
    mon_valid = 1; mon_write = wr; mon_id = id; mon_addr = a;
    step();
    mon_valid = 0;
  endtask

  function automatic logic [AW-1:0] raddr();
    return {TW'(12'h001 + ($urandom % 3)), IW'($urandom % NL)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd91));
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_s[i] = 0; m_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", int'(cpu_req_ready), 1);
    chk(bus_req == 1'b0, "R1 no bus request after reset", int'(bus_req), 0);
    chk(cpu_rsp_valid == 1'b0, "R1 no response after reset", int'(cpu_rsp_valid), 0);

    access(16'h1235, 0, "R1 cold access misses");
    chk(!cpu_req_ready, "R3 ready low on miss", int'(cpu_req_ready), 0);
    serve(16'h1235, "R3 refill address", 0);
    access(16'h1235, 1, "R3 hit after refill");

    fwrite(16'h1235, 2'd1, 1);
    access(16'h1235, 0, "R4 stale line misses");
    serve(16'h1235, "R4 stale refetch address", 0);
    access(16'h1235, 1, "R4 hit after refetch");
    fwrite(16'h1235, 2'd2, 0);
    access(16'h1235, 1, "R4 foreign read ignored");
    fwrite(16'h2235, 2'd3, 1);
    access(16'h1235, 1, "R4 other tag ignored");
    fwrite(16'h1235, 2'd0, 1);
    access(16'h1235, 1, "R5 own write ignored");

    fwrite(16'h1235, 2'd1, 1);
    for (int k = 0; k < 6; k++) begin
      step(); chk(!bus_req, "R6 disabled engine idle", int'(bus_req), 0);
    end
    bus_busy = 1; bg_en = 1;
    for (int k = 0; k < 4; k++) begin
      step(); chk(!bus_req, "R6 busy bus blocks engine", int'(bus_req), 0);
    end
    bus_busy = 0;
    serve(16'h1235, "R6 background refill address", 0);
    bg_en = 0;
    access(16'h1235, 1, "R6 hit after background refill");

    access(16'h1002, 0, "R7 setup miss"); serve(16'h1002, "R7 setup", 0);
    access(16'h1007, 0, "R7 setup miss"); serve(16'h1007, "R7 setup", 0);
    access(16'h100C, 0, "R7 setup miss"); serve(16'h100C, "R7 setup", 0);
    fwrite(16'h1002, 2'd1, 1);
    fwrite(16'h1007, 2'd2, 1);
    fwrite(16'h100C, 2'd3, 1);
    bg_en = 1;
    serve(16'h1007, "R7 first in circular order", 0);
    serve(16'h100C, "R7 second in circular order", 0);
    serve(16'h1002, "R7 wraps around", 0);
    bg_en = 0;

    fwrite(16'h1007, 2'd1, 1);
    bg_en = 1;
    for (int k = 0; k < 20 && !bus_req; k++) step();
    chk(bus_req && bus_addr == 16'h1007, "R8 background request seen", int'(bus_addr), 16'h1007);
    step();
    chk(bus_req, "R10 request held without grant", int'(bus_req), 1);
    access(16'h3003, 0, "R8 miss during background request");
    step();
    chk(bus_req && bus_addr == 16'h3003, "R8 miss overrides ungranted request", int'(bus_addr), 16'h3003);
    serve(16'h3003, "R8 miss refill", 0);
    serve(16'h1007, "R8 background resumes", 0);

    fwrite(16'h100C, 2'd2, 1);
    for (int k = 0; k < 20 && !bus_req; k++) step();
    chk(bus_addr == 16'h100C, "R8 second background request", int'(bus_addr), 16'h100C);
    bus_gnt = 1; step(); bus_gnt = 0;
    access(16'h4004, 0, "R8 miss after grant");
    for (int k = 0; k < 2; k++) begin
      step(); chk(!bus_req, "R8 granted refill keeps bus", int'(bus_req), 0);
    end
    bus_dvalid = 1; step(); bus_dvalid = 0;
    serve(16'h4004, "R8 miss issued after granted refill", 0);
    bg_en = 0;
    access(16'h100C, 1, "R8 background line hits");

    fwrite(16'h1235, 2'd1, 1);
    access(16'h1235, 0, "R9 setup miss");
    serve(16'h1235, "R9 refill address", 1);
    access(16'h1235, 0, "R9 snoop in strobe cycle wins");
    serve(16'h1235, "R9 refetch", 0);
    access(16'h1235, 1, "R9 line clean after refetch");

    for (int c = 0; c < 4000; c++) begin
      if (c % 700 == 0) bg_en = ~bg_en;
      if (!cpu_req_valid || last_acc) begin
        cpu_req_valid = ($urandom % 5) < 2;
        cpu_req_addr  = raddr();
      end
      mon_valid = ($urandom % 4) == 0;
      mon_write = $urandom % 2;
      mon_id    = 2'($urandom % 4);
      mon_addr  = raddr();
      bus_busy  = $urandom % 2;
      bus_gnt   = 0; bus_dvalid = 0;
      if (xfer) bus_dvalid = $urandom % 2;
      else if (bus_req) bus_gnt = ($urandom % 3) == 0;
      step();
    end
    cpu_req_valid = 0; mon_valid = 0; bus_gnt = 0; bus_dvalid = 0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule